// File: doc/BRIEF.md
# Per-Port Packet-Bus Loopback with Header Insertion

This block sits on the system-side packet bus of a four-port MAC and provides a diagnostic return path. Every word presented on the transmit side of the bus is forwarded, unchanged and one cycle later, to the line-side transmit output. For each port whose loopback bit is set, the same packet is also sent back on the receive side of the bus. Other ports carry on in normal mode at the same time.

An optional header mode places two zero bytes in front of each looped packet. The payload is then shifted by two byte lanes, and the packet may grow by one trailing word. Because that extra word needs a slot on the receive bus, header mode requires at least one idle cycle between one packet's end and the next packet's start. A small spacing monitor detects start-of-packet arriving on the cycle right after end-of-packet while header mode is on. When that happens it raises a sticky error flag and keeps the offending packet out of the loopback path. That packet is still forwarded to the line output.

Software programs a single configuration write that holds one loopback bit per port and the header-mode bit. Packets do not interleave on the bus: each runs from its start word to its end word before the next one begins.

Top module: `pkt_loopback`

## Requirements
- R1: After synchronous reset all loopback bits and the header mode are cleared, the error flag is low and neither output bus is valid; a packet sent after reset goes to the line output only.
- R2: Every valid transmit word appears on the line outputs exactly one cycle later, with data, sop, eop, mod and port unchanged, whatever the loopback setting.
- R3: A write with cfg_we loads cfg_lb_en (bit n enables port n) and cfg_prepend, effective from the next cycle; with header mode off, each word of a packet on an enabled port appears on the receive outputs one cycle later with identical data, sop, eop, mod and port.
- R4: Packets on ports whose loopback bit is clear produce no receive output, while enabled ports loop back in the same run.
- R5: The loopback bit is sampled only on a packet's start word; a change written during a packet affects the next packet of that port, not the current one.
- R6: With header mode off, a start word on the cycle right after an end word is looped back, and the receive words follow each other with no idle cycle.
- R7: With header mode on, byte 0 of a word is bits [31:24]; looped word k carries the low 16 bits of transmit word k-1 followed by the high 16 bits of transmit word k, with zero in place of word -1.
- R8: mod counts the unused trailing bytes of an end word (0 to 3). With header mode on, a transmit end word with mod 2 or 3 ends the looped packet on its own shifted word with mod reduced by 2; with mod 0 or 1, one extra word {last[15:0], 16'h0} follows with eop and mod increased by 2, two cycles after the transmit end word.
- R9: With header mode on, a start word on the cycle right after an end word sets the error flag and that packet gives no receive output, while still appearing on the line outputs.
- R10: The error flag stays set until reset, and later correctly spaced packets loop back normally.
- R11: Receive sop and port appear one cycle after the matching transmit start word, with or without header mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lb_en | input | 4 | Loopback bits, bit n for port n |
| cfg_prepend | input | 1 | Header mode enable |
| tx_valid | input | 1 | Transmit word valid |
| tx_sop | input | 1 | Transmit start of packet |
| tx_eop | input | 1 | Transmit end of packet |
| tx_port | input | 2 | Transmit port address |
| tx_mod | input | 2 | Unused trailing bytes of the end word |
| tx_data | input | 32 | Transmit data, byte 0 in [31:24] |
| ln_valid | output | 1 | Line-side word valid |
| ln_sop | output | 1 | Line-side start of packet |
| ln_eop | output | 1 | Line-side end of packet |
| ln_port | output | 2 | Line-side port address |
| ln_mod | output | 2 | Line-side unused trailing bytes |
| ln_data | output | 32 | Line-side data |
| rx_valid | output | 1 | Receive word valid |
| rx_sop | output | 1 | Receive start of packet |
| rx_eop | output | 1 | Receive end of packet |
| rx_port | output | 2 | Receive port address |
| rx_mod | output | 2 | Receive unused trailing bytes |
| rx_data | output | 32 | Receive data |
| err_gap | output | 1 | Sticky packet-spacing error |

## Verification
The assertions check on every cycle that line words mirror the transmit words one cycle later, that a receive start word always follows a transmit start word on the same port, that a start word on a disabled port gives no receive start, that a badly spaced start word in header mode raises the flag and is not looped, and that the flag never falls. Only the bench scenarios can show the shifted byte content, the mod values and the timing of the extra tail word, back-to-back looping without a gap, and sampling of the enable only on the start word.

// File: rtl/lb_pkg.sv
package lb_pkg;
    localparam int NPORT      = 4;
    localparam int DW         = 32;
    localparam int BYTES      = DW / 8;
    localparam int PW         = $clog2(NPORT);
    localparam int MW         = $clog2(BYTES);
    localparam int HW         = DW / 2;
    localparam int PRE_BYTES  = 2;

    localparam logic [MW-1:0] PRE_MOD = MW'(PRE_BYTES);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          sop;
        logic          eop;
        logic [MW-1:0] mod;
        logic [PW-1:0] port;
    } bus_word_t;

    // an end word whose used bytes fit behind the carried half word
    function automatic logic ends_in_place(input logic [MW-1:0] mod);
        return mod >= PRE_MOD;
    endfunction
endpackage

// File: rtl/lb_cfg_reg.sv
module lb_cfg_reg
    import lb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [NPORT-1:0] lb_in,
    input  logic             pre_in,
    output logic [NPORT-1:0] lb_q,
    output logic             pre_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lb_q  <= '0;
            pre_q <= 1'b0;
        end else if (we) begin
            lb_q  <= lb_in;
            pre_q <= pre_in;
        end
    end
endmodule

// File: rtl/lb_gap_mon.sv
module lb_gap_mon (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic sop,
    input  logic eop,
    input  logic pre,
    output logic viol,
    output logic err
);
    logic last_eop_q;

    assign viol = pre & valid & sop & last_eop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_eop_q <= 1'b0;
            err        <= 1'b0;
        end else begin
            last_eop_q <= valid & eop;
            err        <= err | viol;
        end
    end
endmodule

// File: rtl/lb_rx_path.sv
module lb_rx_path
    import lb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_word_t        in_w,
    input  logic             in_valid,
    input  logic [NPORT-1:0] lb_q,
    input  logic             pre_q,
    input  logic             viol,
    output bus_word_t        out_w,
    output logic             out_valid
);
    logic          active_q;
    logic          pp_q;
    logic          pend_q;
    logic [PW-1:0] port_q;
    logic [HW-1:0] hold_q;
    logic [MW-1:0] pend_mod_q;

    logic          sel_en;
    logic          take;
    logic          eff_pp;
    logic [PW-1:0] eff_port;
    logic [HW-1:0] prev_low;
    logic [DW-1:0] shifted;

    always_comb begin
        sel_en   = lb_q[in_w.port] & ~viol;
        take     = in_valid & (in_w.sop ? sel_en : active_q);
        eff_pp   = in_w.sop ? pre_q : pp_q;
        eff_port = in_w.sop ? in_w.port : port_q;
        prev_low = in_w.sop ? '0 : hold_q;
        shifted  = {prev_low, in_w.data[DW-1:HW]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            pp_q       <= 1'b0;
            pend_q     <= 1'b0;
            port_q     <= '0;
            hold_q     <= '0;
            pend_mod_q <= '0;
            out_w      <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_w.sop <= 1'b0;
            out_w.eop <= 1'b0;

            if (in_valid) begin
                if (in_w.sop) begin
                    active_q <= sel_en & ~in_w.eop;
                    pp_q     <= pre_q;
                    port_q   <= in_w.port;
                end else if (in_w.eop) begin
                    active_q <= 1'b0;
                end
            end

            if (pend_q) begin
                out_valid  <= 1'b1;
                out_w.data <= {hold_q, {HW{1'b0}}};
                out_w.eop  <= 1'b1;
                out_w.mod  <= pend_mod_q;
                out_w.port <= port_q;
                pend_q     <= 1'b0;
            end else if (take) begin
                out_valid  <= 1'b1;
                out_w.sop  <= in_w.sop;
                out_w.port <= eff_port;
                if (!eff_pp) begin
                    out_w.data <= in_w.data;
                    out_w.eop  <= in_w.eop;
                    out_w.mod  <= in_w.mod;
                end else begin
                    out_w.data <= shifted;
                    hold_q     <= in_w.data[HW-1:0];
                    if (in_w.eop && ends_in_place(in_w.mod)) begin
                        out_w.eop <= 1'b1;
                        out_w.mod <= in_w.mod - PRE_MOD;
                    end else begin
                        out_w.mod <= '0;
                        if (in_w.eop) begin
                            pend_q     <= 1'b1;
                            pend_mod_q <= in_w.mod + PRE_MOD;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pkt_loopback.sv
module pkt_loopback
    import lb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [NPORT-1:0] cfg_lb_en,
    input  logic             cfg_prepend,
    input  logic             tx_valid,
    input  logic             tx_sop,
    input  logic             tx_eop,
    input  logic [PW-1:0]    tx_port,
    input  logic [MW-1:0]    tx_mod,
    input  logic [DW-1:0]    tx_data,
    output logic             ln_valid,
    output logic             ln_sop,
    output logic             ln_eop,
    output logic [PW-1:0]    ln_port,
    output logic [MW-1:0]    ln_mod,
    output logic [DW-1:0]    ln_data,
    output logic             rx_valid,
    output logic             rx_sop,
    output logic             rx_eop,
    output logic [PW-1:0]    rx_port,
    output logic [MW-1:0]    rx_mod,
    output logic [DW-1:0]    rx_data,
    output logic             err_gap
);
    bus_word_t        tx_w;
    bus_word_t        ln_q;
    bus_word_t        rx_w;
    logic             ln_valid_q;
    logic [NPORT-1:0] lb_q;
    logic             pre_q;
    logic             viol;

    assign tx_w = '{data: tx_data, sop: tx_sop, eop: tx_eop, mod: tx_mod, port: tx_port};

    lb_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .lb_in  (cfg_lb_en),
        .pre_in (cfg_prepend),
        .lb_q   (lb_q),
        .pre_q  (pre_q)
    );

    lb_gap_mon u_gap (
        .clk   (clk),
        .rst   (rst),
        .valid (tx_valid),
        .sop   (tx_sop),
        .eop   (tx_eop),
        .pre   (pre_q),
        .viol  (viol),
        .err   (err_gap)
    );

    lb_rx_path u_rx (
        .clk       (clk),
        .rst       (rst),
        .in_w      (tx_w),
        .in_valid  (tx_valid),
        .lb_q      (lb_q),
        .pre_q     (pre_q),
        .viol      (viol),
        .out_w     (rx_w),
        .out_valid (rx_valid)
    );

    // line-side copy of every transmit word
    always_ff @(posedge clk) begin
        if (rst) begin
            ln_q       <= '0;
            ln_valid_q <= 1'b0;
        end else begin
            ln_valid_q <= tx_valid;
            if (tx_valid) begin
                ln_q <= tx_w;
            end else begin
                ln_q.sop <= 1'b0;
                ln_q.eop <= 1'b0;
            end
        end
    end

    assign ln_valid = ln_valid_q;
    assign ln_sop   = ln_q.sop;
    assign ln_eop   = ln_q.eop;
    assign ln_port  = ln_q.port;
    assign ln_mod   = ln_q.mod;
    assign ln_data  = ln_q.data;

    assign rx_sop  = rx_w.sop;
    assign rx_eop  = rx_w.eop;
    assign rx_port = rx_w.port;
    assign rx_mod  = rx_w.mod;
    assign rx_data = rx_w.data;
endmodule

// File: rtl/lb_loopback_chk.sv
module lb_loopback_chk
    import lb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tx_valid,
    input logic             tx_sop,
    input logic             tx_eop,
    input logic [PW-1:0]    tx_port,
    input logic [MW-1:0]    tx_mod,
    input logic [DW-1:0]    tx_data,
    input logic             ln_valid,
    input logic [PW-1:0]    ln_port,
    input logic [MW-1:0]    ln_mod,
    input logic [DW-1:0]    ln_data,
    input logic             rx_valid,
    input logic             rx_sop,
    input logic [PW-1:0]    rx_port,
    input logic             err_gap,
    input logic [NPORT-1:0] lb_q,
    input logic             pre_q
);
    logic prev_eop_q;

    always_ff @(posedge clk) begin
        if (rst) prev_eop_q <= 1'b0;
        else     prev_eop_q <= tx_valid & tx_eop;
    end

    // R2
    line_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ln_valid |-> ($past(tx_valid) && ln_data == $past(tx_data)
                      && ln_port == $past(tx_port) && ln_mod == $past(tx_mod)));

    // R11
    rx_start_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sop) |-> ($past(tx_valid && tx_sop) && rx_port == $past(tx_port)));

    // R4
    disabled_port_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_sop && !lb_q[tx_port]) |=> !(rx_valid && rx_sop));

    // R9
    gap_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_sop && prev_eop_q && pre_q) |=> (err_gap && !(rx_valid && rx_sop)));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_gap |=> err_gap);
endmodule

bind pkt_loopback lb_loopback_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_sop   (tx_sop),
    .tx_eop   (tx_eop),
    .tx_port  (tx_port),
    .tx_mod   (tx_mod),
    .tx_data  (tx_data),
    .ln_valid (ln_valid),
    .ln_port  (ln_port),
    .ln_mod   (ln_mod),
    .ln_data  (ln_data),
    .rx_valid (rx_valid),
    .rx_sop   (rx_sop),
    .rx_port  (rx_port),
    .err_gap  (err_gap),
    .lb_q     (lb_q),
    .pre_q    (pre_q)
);

// File: tb/pkt_loopback_tb.sv
`timescale 1ns/1ps
module pkt_loopback_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_lb_en = '0;
    logic        cfg_prepend = 1'b0;
    logic        tx_valid = 1'b0, tx_sop = 1'b0, tx_eop = 1'b0;
    logic [1:0]  tx_port = '0, tx_mod = '0;
    logic [31:0] tx_data = '0;
    logic        ln_valid, ln_sop, ln_eop;
    logic [1:0]  ln_port, ln_mod;
    logic [31:0] ln_data;
    logic        rx_valid, rx_sop, rx_eop;
    logic [1:0]  rx_port, rx_mod;
    logic [31:0] rx_data;
    logic        err_gap;

    always #10 clk = ~clk;

    pkt_loopback u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lb_en(cfg_lb_en),
        .cfg_prepend(cfg_prepend), .tx_valid(tx_valid), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_port(tx_port), .tx_mod(tx_mod), .tx_data(tx_data),
        .ln_valid(ln_valid), .ln_sop(ln_sop), .ln_eop(ln_eop), .ln_port(ln_port),
        .ln_mod(ln_mod), .ln_data(ln_data), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_port(rx_port), .rx_mod(rx_mod), .rx_data(rx_data),
        .err_gap(err_gap)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    int drv_cyc = 0;

    logic [63:0] cap_rx [64]; int cap_rx_c [64]; int n_cap_rx = 0;
    logic [63:0] cap_ln [64]; int cap_ln_c [64]; int n_cap_ln = 0;
    logic [63:0] exp_rx [64]; int exp_rx_c [64]; int n_exp_rx = 0;
    logic [63:0] exp_ln [64]; int exp_ln_c [64]; int n_exp_ln = 0;

    // bench model of the configuration and spacing state
    logic [3:0]  m_lb = '0;
    bit          m_pre = 0, m_err = 0, m_prev_eop = 0, m_take = 0, m_pp = 0;
    logic [15:0] m_hold = '0;
    logic [15:0] seed = 16'h1200;

    function automatic logic [63:0] pack(logic [31:0] d, logic s, logic e, logic [1:0] m, logic [1:0] p);
        return {26'h0, d, s, e, m, p};
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid && n_cap_rx < 64) begin
                cap_rx[n_cap_rx] = pack(rx_data, rx_sop, rx_eop, rx_mod, rx_port);
                cap_rx_c[n_cap_rx] = cyc;
                n_cap_rx++;
            end
            if (ln_valid && n_cap_ln < 64) begin
                cap_ln[n_cap_ln] = pack(ln_data, ln_sop, ln_eop, ln_mod, ln_port);
                cap_ln_c[n_cap_ln] = cyc;
                n_cap_ln++;
            end
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input bit s, input bit e, input logic [1:0] p,
                         input logic [31:0] d, input logic [1:0] m, input bit we,
                         input logic [3:0] lb, input bit pre);
        @(negedge clk);
        tx_valid = v; tx_sop = s; tx_eop = e; tx_port = p; tx_data = d; tx_mod = m;
        cfg_we = we; cfg_lb_en = lb; cfg_prepend = pre;
        drv_cyc = cyc;
    endtask

    task automatic idle();
        drive(0, 0, 0, 2'd0, 32'h0, 2'd0, 0, m_lb, m_pre);
        m_prev_eop = 0;
    endtask

    task automatic push_rx(input logic [31:0] d, input logic s, input logic e,
                           input logic [1:0] m, input logic [1:0] p, input int c);
        exp_rx[n_exp_rx] = pack(d, s, e, m, p); exp_rx_c[n_exp_rx] = c; n_exp_rx++;
    endtask

    task automatic set_cfg(input logic [3:0] lb, input bit pre);
        drive(0, 0, 0, 2'd0, 32'h0, 2'd0, 1, lb, pre);
        m_lb = lb; m_pre = pre; m_prev_eop = 0;
        idle();
    endtask

    task automatic send_pkt(input logic [1:0] port, input int n, input logic [1:0] mod,
                            input int gap, input int cfg_at, input logic [3:0] newlb);
        for (int i = 0; i < n; i++) begin
            bit s, e, viol;
            logic [31:0] d;
            logic [1:0] mm;
            s = (i == 0); e = (i == n - 1);
            d = {seed, 8'(i), 8'h3C};
            mm = e ? mod : 2'd0;
            drive(1, s, e, port, d, mm, (i == cfg_at), (i == cfg_at) ? newlb : m_lb, m_pre);
            exp_ln[n_exp_ln] = pack(d, s, e, mm, port); exp_ln_c[n_exp_ln] = drv_cyc + 1; n_exp_ln++;
            if (s) begin
                viol = m_pre && m_prev_eop;
                if (viol) m_err = 1;
                m_take = m_lb[port] && !viol;
                m_pp = m_pre;
                m_hold = '0;
            end
            if (m_take) begin
                if (!m_pp) begin
                    push_rx(d, s, e, mm, port, drv_cyc + 1);
                end else begin
                    if (e && mod >= 2) push_rx({m_hold, d[31:16]}, s, 1, mod - 2, port, drv_cyc + 1);
                    else               push_rx({m_hold, d[31:16]}, s, 0, 2'd0, port, drv_cyc + 1);
                    if (e && mod < 2)  push_rx({d[15:0], 16'h0}, 0, 1, mod + 2, port, drv_cyc + 2);
                    m_hold = d[15:0];
                end
            end
            if (i == cfg_at) m_lb = newlb;
            m_prev_eop = e;
        end
        seed++;
        for (int g = 0; g < gap; g++) idle();
    endtask

    task automatic finish_scn(input string req);
        for (int k = 0; k < 4; k++) idle();
        check(req, "rx word count", 64'(n_cap_rx), 64'(n_exp_rx));
        for (int i = 0; i < n_exp_rx && i < n_cap_rx; i++) begin
            check(req, $sformatf("rx word %0d", i), cap_rx[i], exp_rx[i]);
            check(req, $sformatf("rx word %0d cycle", i), 64'(cap_rx_c[i]), 64'(exp_rx_c[i]));
        end
        check("R2", "line word count", 64'(n_cap_ln), 64'(n_exp_ln));
        for (int i = 0; i < n_exp_ln && i < n_cap_ln; i++) begin
            check("R2", $sformatf("line word %0d", i), cap_ln[i], exp_ln[i]);
            check("R2", $sformatf("line word %0d cycle", i), 64'(cap_ln_c[i]), 64'(exp_ln_c[i]));
        end
        check(req, "error flag", 64'(err_gap), 64'(m_err));
        n_cap_rx = 0; n_cap_ln = 0; n_exp_rx = 0; n_exp_ln = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        tx_valid = 0; tx_sop = 0; tx_eop = 0; cfg_we = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_lb = '0; m_pre = 0; m_err = 0; m_prev_eop = 0; m_take = 0;
        n_cap_rx = 0; n_cap_ln = 0; n_exp_rx = 0; n_exp_ln = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "rx_valid after reset", 64'(rx_valid), 64'd0);
        check("R1", "ln_valid after reset", 64'(ln_valid), 64'd0);
        check("R1", "err_gap after reset", 64'(err_gap), 64'd0);
        send_pkt(2'd0, 2, 2'd1, 1, -1, 4'd0);
        send_pkt(2'd3, 1, 2'd0, 1, -1, 4'd0);
        finish_scn("R1");
    endtask

    task automatic t_basic();
        set_cfg(4'b0010, 0);
        send_pkt(2'd1, 3, 2'd1, 1, -1, 4'd0);
        send_pkt(2'd1, 1, 2'd3, 1, -1, 4'd0);
        finish_scn("R3/R11");
    endtask

    task automatic t_isolation();
        set_cfg(4'b1010, 0);
        send_pkt(2'd2, 2, 2'd0, 1, -1, 4'd0);
        send_pkt(2'd3, 2, 2'd2, 1, -1, 4'd0);
        send_pkt(2'd0, 1, 2'd1, 1, -1, 4'd0);
        send_pkt(2'd1, 2, 2'd0, 1, -1, 4'd0);
        finish_scn("R4");
    endtask

    task automatic t_midpkt();
        set_cfg(4'b0010, 0);
        send_pkt(2'd1, 4, 2'd2, 1, 2, 4'b1000);
        send_pkt(2'd1, 2, 2'd0, 1, -1, 4'd0);
        send_pkt(2'd2, 3, 2'd0, 1, 1, 4'b1100);
        send_pkt(2'd2, 2, 2'd3, 1, -1, 4'd0);
        finish_scn("R5");
    endtask

    task automatic t_b2b();
        set_cfg(4'b0010, 0);
        send_pkt(2'd1, 2, 2'd1, 0, -1, 4'd0);
        send_pkt(2'd1, 2, 2'd2, 0, -1, 4'd0);
        send_pkt(2'd1, 1, 2'd3, 1, -1, 4'd0);
        finish_scn("R6");
    endtask

    task automatic t_pre_short();
        set_cfg(4'b0010, 1);
        send_pkt(2'd1, 2, 2'd2, 1, -1, 4'd0);
        send_pkt(2'd1, 1, 2'd3, 1, -1, 4'd0);
        send_pkt(2'd1, 3, 2'd2, 1, -1, 4'd0);
        send_pkt(2'd0, 2, 2'd2, 1, -1, 4'd0);
        finish_scn("R7");
    endtask

    task automatic t_pre_long();
        set_cfg(4'b0010, 1);
        send_pkt(2'd1, 2, 2'd0, 1, -1, 4'd0);
        send_pkt(2'd1, 1, 2'd1, 1, -1, 4'd0);
        send_pkt(2'd1, 3, 2'd1, 1, -1, 4'd0);
        finish_scn("R8");
    endtask

    task automatic t_gap();
        set_cfg(4'b0010, 1);
        send_pkt(2'd1, 2, 2'd2, 0, -1, 4'd0);
        send_pkt(2'd1, 2, 2'd0, 1, -1, 4'd0);
        finish_scn("R9");
        send_pkt(2'd1, 2, 2'd3, 1, -1, 4'd0);
        finish_scn("R10");
        do_reset();
        check("R10", "error flag cleared by reset", 64'(err_gap), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_isolation();
        t_midpkt();
        t_b2b();
        t_pre_short();
        t_pre_long();
        t_gap();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule